// File: doc/BRIEF.md
# Register-Fed CRC-16 Engine with Input Counter

This block computes a 16-bit CCITT CRC over bytes that software hands to it one register write at a time. A clear request puts the engine back to its starting state. Each write to the data register folds one byte into the running checksum. The current checksum and a count of the bytes absorbed so far can be read back at any time through a small 16-bit register port.

Typical uses are checking a received frame after the fact, and a bring-up self-test. In the self-test, software clears the engine, feeds a fixed four-byte pattern and compares both the count and the checksum against known answers.

The port has one read address, one shared write data word and two write strobes: one for the control register and one for the data register. Because the strobes are separate, a clear and a data byte can be issued in the same clock.

Top module: `crc16_regport`

## Requirements
- R1: After the hardware reset (rst_n low), the count reads 0 and the checksum register reads 0x0000.
- R2: A control write (ctl_we) with wdata bit 15 set restores the initial checksum state and sets the count to 0. A control write with bit 15 clear changes neither the count nor the checksum.
- R3: Read address 0 returns the count in bits 11:0, with bits 15:12 reading 0. Address 2 returns the checksum. Addresses 1 and 3 read 0.
- R4: Each data write (din_we) folds wdata bits 7:0 into the checksum, least significant bit first. The polynomial is x^16+x^12+x^5+1 in reflected form 0x8408, the start value is 0xFFFF, and the value read back is the one's complement of the internal state. Bits 15:8 of the data word have no effect.
- R5: Each data write raises the count by one, and the count stays at 0xFFF once it reaches 0xFFF.
- R6: After a clear, writing the bytes 0xCC, 0xF5, 0xF1, 0xA7 leaves the count at 4 and the checksum at 0x51DF.
- R7: The updated count and checksum can be read in the cycle right after the write.
- R8: A clear and a data write in the same cycle act as a clear followed by that byte: the count becomes 1 and the checksum is that of the single byte.
- R9: In a cycle with neither strobe asserted, the count and the checksum hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Write strobe for the control register (bit 15 requests a clear) |
| din_we | input | 1 | Write strobe for the data register (bits 7:0 are the byte) |
| wdata | input | 16 | Write data shared by both strobes |
| raddr | input | 2 | Read address: 0 control/count, 1 data, 2 checksum, 3 unused |
| rdata | output | 16 | Read data, combinational from raddr |

## Verification
A corrupted checksum state or a wrong bit order shows up at address 2 in the very next cycle after the faulty write. The error then propagates into every later value, so one bad fold can never be masked by later bytes. A miscounting or wrapping counter appears at address 0 one cycle after the write that disturbs it. The saturation run exposes a wrap at 0xFFF right after the 4096th byte. The known-answer sequence pins down the start value, the reflection and the output complement together, because any single mistake among them changes the final 0x51DF.

// File: rtl/crc16_regport.sv
module crc16_regport #(
  parameter int DW       = 16,
  parameter int CW       = 12,
  parameter int CRC_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int CLR_BIT  = 15,
  parameter logic [CRC_W-1:0] POLY   = 16'h8408,
  parameter logic [CRC_W-1:0] INIT   = 16'hFFFF,
  parameter logic [CRC_W-1:0] XOROUT = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          din_we,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    raddr,
  output logic [DW-1:0] rdata
);

  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_SUM = 2'd2;

  logic [CRC_W-1:0] crc_q, crc_base, crc_d;
  logic [CW-1:0]    cnt_q, cnt_base, cnt_d;
  logic             clr;

  function automatic logic [CRC_W-1:0] fold(input logic [CRC_W-1:0] c,
                                            input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  assign clr      = ctl_we & wdata[CLR_BIT];
  assign crc_base = clr ? INIT : crc_q;
  assign cnt_base = clr ? '0 : cnt_q;
  assign crc_d    = din_we ? fold(crc_base, wdata[BYTE_W-1:0]) : crc_base;
  assign cnt_d    = (din_we && cnt_base != CNT_MAX) ? cnt_base + 1'b1 : cnt_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q <= INIT;
      cnt_q <= '0;
    end else begin
      crc_q <= crc_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    case (raddr)
      A_CTL:   rdata = {{(DW-CW){1'b0}}, cnt_q};
      A_SUM:   rdata = DW'(crc_q ^ XOROUT);
      default: rdata = '0;
    endcase
  end

  AST_RST_STATE: assert property (@(posedge clk) !rst_n |=> cnt_q == '0 && crc_q == INIT); // R1
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && wdata[CLR_BIT] && !din_we |=> cnt_q == '0 && crc_q == INIT); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    din_we && !(ctl_we && wdata[CLR_BIT]) && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1); // R5
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    din_we && !(ctl_we && wdata[CLR_BIT]) && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX); // R5
  AST_CLR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && wdata[CLR_BIT] && din_we |=> cnt_q == CW'(1)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !din_we && !(ctl_we && wdata[CLR_BIT]) |=> $stable(cnt_q) && $stable(crc_q)); // R9

endmodule

// File: tb/test_crc16_regport.sv
module test_crc16_regport;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctl_we = 0;
  logic        din_we = 0;
  logic [15:0] wdata = '0;
  logic [1:0]  raddr = '0;
  logic [15:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [15:0] m_crc = 16'hFFFF;
  logic [11:0] m_cnt = '0;

  crc16_regport i_crc16_regport (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .din_we(din_we),
    .wdata(wdata), .raddr(raddr), .rdata(rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    raddr = a;
    #1;
    v = rdata;
  endtask

  task automatic check_state(input string req);
    logic [15:0] v;
    rd(2'd0, v); chk({req, " count"}, v, {4'h0, m_cnt});
    rd(2'd2, v); chk({req, " checksum"}, v, ~m_crc);
  endtask

  task automatic op(input bit c, input bit d, input logic [15:0] wd);
    @(negedge clk);
    ctl_we = c; din_we = d; wdata = wd;
    @(negedge clk);
    ctl_we = 0; din_we = 0; wdata = $urandom();
    if (c && wd[15]) begin m_crc = 16'hFFFF; m_cnt = '0; end
    if (d) begin
      m_crc = ref_byte(m_crc, wd[7:0]);
      if (m_cnt != 12'hFFF) m_cnt = m_cnt + 1'b1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] kat [4];
    kat[0] = 16'hA5CC; kat[1] = 16'h3EF5; kat[2] = 16'hF7F1; kat[3] = 16'h00A7;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_state("R1 reset");
    rd(2'd1, v); chk("R3 addr1 reads zero", v, 16'h0000);
    rd(2'd3, v); chk("R3 addr3 reads zero", v, 16'h0000);

    // R6 known answer, upper data bits set to show R4 ignores them
    op(1, 0, 16'h8000);
    check_state("R2 clear");
    for (int i = 0; i < 4; i++) begin
      op(0, 1, kat[i]);
      check_state("R7 next-cycle update");
    end
    rd(2'd0, v); chk("R6 known-answer count", v, 16'h0004);
    rd(2'd2, v); chk("R6 known-answer checksum", v, 16'h51DF);

    op(1, 0, 16'h7FFF);
    check_state("R2 control write without clear bit");
    repeat (5) @(negedge clk);
    check_state("R9 idle hold");

    op(0, 1, 16'h0012);
    op(1, 1, 16'h80CC);
    check_state("R8 clear with data");
    rd(2'd0, v); chk("R8 count is one", v, 16'h0001);
    rd(2'd2, v); chk("R8 single-byte checksum", v, ~ref_byte(16'hFFFF, 8'hCC));

    for (int i = 0; i < 400; i++) begin
      int kind;
      logic [15:0] wd;
      kind = $urandom_range(0, 9);
      wd = $urandom();
      case (kind)
        0, 1, 2, 3, 4, 5: op(0, 1, wd);
        6: op(1, 0, wd | 16'h8000);
        7: op(1, 0, wd & 16'h7FFF);
        8: op(1, 1, wd | 16'h8000);
        default: @(negedge clk);
      endcase
      check_state("R4 random mix");
    end

    op(1, 0, 16'h8000);
    for (int i = 0; i < 4100; i++) op(0, 1, 16'($urandom()));
    rd(2'd0, v); chk("R5 saturated count", v, 16'h0FFF);
    check_state("R5 saturation checksum");
    rd(2'd0, v); chk("R3 upper control bits zero", v & 16'hF000, 16'h0000);

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    m_crc = 16'hFFFF; m_cnt = '0;
    check_state("R1 reset after use");
    finish_run();
  end
endmodule